// File: doc/BRIEF.md
# Dual-Convention Stack Pointer Engine

This block owns a 16-bit stack pointer and carries out byte and word push and pop operations on a memory that is one byte wide. A client raises a push or pop request together with a size flag. The engine then issues the byte accesses one after another and moves the pointer. When the operation is finished it pulses a completion strobe. For a pop, the value read is presented on a data output when that strobe is high. Words are kept big-endian: the more significant byte sits at the lower address.

A mode input selects the stack discipline for each request, and it is sampled when the request is accepted. In the free-slot discipline the pointer addresses the next unused byte: the engine writes first and then moves the pointer. In the occupied-slot discipline the pointer addresses the byte pushed most recently: the engine moves the pointer first and then writes at the new position. The memory port has a read latency of one cycle. All pointer arithmetic wraps modulo 2^16.

Top module: `stk_engine`

## Requirements
- R1: Free-slot mode (mode_last_used=0), byte push: the low byte of push_data is written at address SP, and SP becomes SP-1.
- R2: Free-slot mode, word push: push_data[15:8] is written at SP-1 and push_data[7:0] at SP, in that order, and SP becomes SP-2.
- R3: Free-slot mode, pop: a byte pop reads address SP+1 and SP becomes SP+1. A word pop reads SP+1 (the high byte) and then SP+2 (the low byte), and SP becomes SP+2.
- R4: Occupied-slot mode (mode_last_used=1), push: SP first drops by the size (1 or 2). A byte push writes the low byte at the new SP. A word push writes the high byte at the new SP and the low byte at new SP+1.
- R5: Occupied-slot mode, pop: the engine reads starting at SP, with the high byte first for a word, and SP then rises by the size.
- R6: Call the clock edge that accepts a request edge 0. done is high for exactly one cycle, following edge 2 for a byte operation and edge 3 for a word operation. SP takes its new value at that same edge. pop_data holds the popped value while done is high, and a byte pop is zero-extended.
- R7: busy is high from the edge that accepts a request until the edge that raises done. Requests and changes of mode while busy is high have no effect.
- R8: Addresses and SP wrap modulo 2^16, and a word's second byte is at (first address + 1) mod 2^16.
- R9: Memory access is issued only while busy. One byte access is made per cycle, never a read and a write together. If push and pop are requested in the same cycle, the push is carried out.
- R10: After reset SP equals the RESET_SP parameter, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_last_used | input | 1 | 1 = occupied-slot discipline, 0 = free-slot discipline |
| req_push | input | 1 | Push request, taken when idle |
| req_pop | input | 1 | Pop request, taken when idle |
| req_word | input | 1 | 1 = word operand, 0 = byte operand |
| push_data | input | 16 | Value to push (the low byte for a byte push) |
| pop_data | output | 16 | Popped value, valid while done is high |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data returns one cycle later |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |

## Verification
A base or size captured wrongly at acceptance would show at once on mem_addr, in the first busy cycle. A fault in the sequencing state would show up as a missing or extra strobe, or as done arriving a cycle early or late. A wrong pointer result appears on sp_out in the done cycle, and it also moves every address used by the operations that follow. A byte lane that is swapped or captured in the wrong cycle shows on pop_data in the same done cycle. The reference model follows each of these cycle by cycle, including wraps through address zero.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} stk_state_e;

    typedef struct packed {
        stk_state_e         st;
        logic               idx;
        logic               is_push;
        logic               is_word;
        logic [SP_W-1:0]    base;
        logic [SP_W-1:0]    sp;
        logic [SP_W-1:0]    sp_next;
        logic [WORD_W-1:0]  wdata;
        logic               done;
    } stk_regs_t;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] sp,
    input  logic         last_used,
    input  logic         is_push,
    input  logic         is_word,
    output logic [W-1:0] base,
    output logic [W-1:0] sp_new
);
    logic [W-1:0] size;

    always_comb begin
        size = is_word ? W'(2) : W'(1);
        if (last_used) begin
            if (is_push) begin
                sp_new = sp - size;
                base   = sp_new;
            end else begin
                base   = sp;
                sp_new = sp + size;
            end
        end else begin
            if (is_push) begin
                base   = sp - size + W'(1);
                sp_new = sp - size;
            end else begin
                base   = sp + W'(1);
                sp_new = sp + size;
            end
        end
    end
endmodule

// File: rtl/stk_pop_gather.sv
module stk_pop_gather #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_en,
    input  logic          lo_en,
    input  logic          zero_hi,
    input  logic [BW-1:0] rdata,
    output logic [2*BW-1:0] data_out
);
    logic [2*BW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (hi_en) data_d[2*BW-1:BW] = rdata;
        if (lo_en) begin
            data_d[BW-1:0] = rdata;
            if (zero_hi) data_d[2*BW-1:BW] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_out = data_q;
endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter logic [15:0] RESET_SP = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_last_used,
    input  logic        req_push,
    input  logic        req_pop,
    input  logic        req_word,
    input  logic [15:0] push_data,
    output logic [15:0] pop_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] sp_out,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    stk_regs_t r_d, r_q;
    logic [SP_W-1:0] ag_base, ag_sp;

    stk_addr_gen #(.W(SP_W)) u_addr (
        .sp        (r_q.sp),
        .last_used (mode_last_used),
        .is_push   (req_push),
        .is_word   (req_word),
        .base      (ag_base),
        .sp_new    (ag_sp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_push || req_pop) begin
                    r_d.st      = ST_XFER;
                    r_d.idx     = 1'b0;
                    r_d.is_push = req_push;
                    r_d.is_word = req_word;
                    r_d.base    = ag_base;
                    r_d.sp_next = ag_sp;
                    r_d.wdata   = push_data;
                end
            end
            ST_XFER: begin
                if (r_q.is_word && !r_q.idx) r_d.idx = 1'b1;
                else                         r_d.st  = ST_FIN;
            end
            ST_FIN: begin
                r_d.st   = ST_IDLE;
                r_d.sp   = r_q.sp_next;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.sp      <= RESET_SP;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.base + {{(SP_W-1){1'b0}}, r_q.idx};
    assign mem_we    = (r_q.st == ST_XFER) && r_q.is_push;
    assign mem_re    = (r_q.st == ST_XFER) && !r_q.is_push;
    assign mem_wdata = (r_q.is_word && !r_q.idx) ? r_q.wdata[WORD_W-1:BYTE_W]
                                                 : r_q.wdata[BYTE_W-1:0];
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign sp_out    = r_q.sp;

    stk_pop_gather #(.BW(BYTE_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_en    ((r_q.st == ST_XFER) && r_q.idx && !r_q.is_push),
        .lo_en    ((r_q.st == ST_FIN) && !r_q.is_push),
        .zero_hi  (!r_q.is_word),
        .rdata    (mem_rdata),
        .data_out (pop_data)
    );

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_we, mem_re})); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_we || mem_re)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(sp_out)); // R7
    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n) done |-> ((sp_out - $past(sp_out)) == 16'h0001 || (sp_out - $past(sp_out)) == 16'hFFFF || (sp_out - $past(sp_out)) == 16'h0002 || (sp_out - $past(sp_out)) == 16'hFFFE)); // R8
    AST_WORD_ADJ: assert property (@(posedge clk) disable iff (!rst_n) ((mem_we || mem_re) && ($past(mem_we) || $past(mem_re))) |-> (mem_addr == $past(mem_addr) + 16'd1)); // R8
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R7
endmodule

// File: tb/stk_engine_tb_top.sv
module stk_engine_tb_top;
    localparam logic [15:0] INIT_SP = 16'h0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_last_used = 1'b0;
    logic        req_push = 1'b0, req_pop = 1'b0, req_word = 1'b0;
    logic [15:0] push_data = '0;
    logic [15:0] pop_data, sp_out, mem_addr;
    logic        busy, done, mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int sp_model;
    logic [7:0] bmem    [int];
    logic [7:0] ref_mem [int];

    always #5 clk = ~clk;

    stk_engine #(.RESET_SP(INIT_SP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_last_used(mode_last_used),
        .req_push(req_push), .req_pop(req_pop), .req_word(req_word),
        .push_data(push_data), .pop_data(pop_data), .busy(busy), .done(done),
        .sp_out(sp_out), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    task automatic run_op(bit push, bit word, bit lu, logic [15:0] data,
                          string xtag = "", bit both = 0, bit poke = 0);
        int sz, base, newsp, a;
        string tag;
        logic [7:0]  b;
        logic [15:0] exp_pop;
        sz = word ? 2 : 1;
        if (lu) begin
            if (push) begin newsp = (sp_model - sz) & 16'hFFFF; base = newsp; end
            else      begin base = sp_model; newsp = (sp_model + sz) & 16'hFFFF; end
        end else begin
            if (push) begin base = (sp_model - sz + 1) & 16'hFFFF; newsp = (sp_model - sz) & 16'hFFFF; end
            else      begin base = (sp_model + 1) & 16'hFFFF; newsp = (sp_model + sz) & 16'hFFFF; end
        end
        tag = lu ? (push ? "R4" : "R5") : (push ? (word ? "R2" : "R1") : "R3");
        tag = {tag, xtag};
        exp_pop = '0;
        mode_last_used = lu;
        req_push = push | both;
        req_pop  = !push | both;
        req_word = word;
        push_data = data;
        @(negedge clk);
        req_push = 1'b0; req_pop = 1'b0;
        if (poke) begin
            req_push = 1'b1; req_pop = 1'b1; req_word = !word; mode_last_used = !lu;
        end
        for (int k = 0; k < sz; k++) begin
            a = (base + k) & 16'hFFFF;
            chk({tag, " R7"}, "busy", busy, 1'b1);
            chk({tag, " R9"}, "we", mem_we, push);
            chk({tag, " R9"}, "re", mem_re, !push);
            chk(tag, "addr", mem_addr, a);
            if (push) begin
                b = (word && k == 0) ? data[15:8] : data[7:0];
                chk(tag, "wdata", mem_wdata, b);
                ref_mem[a] = b;
            end else begin
                b = ref_rd(a);
                if (word && k == 0) exp_pop[15:8] = b;
                else                exp_pop[7:0]  = b;
            end
            @(negedge clk);
            req_push = 1'b0; req_pop = 1'b0; mode_last_used = lu; req_word = word;
        end
        chk({tag, " R7"}, "busy fin", busy, 1'b1);
        chk({tag, " R6"}, "done early", done, 1'b0);
        chk({tag, " R9"}, "access fin", {mem_we, mem_re}, 2'b00);
        @(negedge clk);
        chk({tag, " R6"}, "done", done, 1'b1);
        chk({tag, " R7"}, "busy at done", busy, 1'b0);
        chk(tag, "sp", sp_out, newsp);
        if (!push) chk({tag, " R6"}, "pop_data", pop_data, exp_pop);
        sp_model = newsp;
        @(negedge clk);
        chk({tag, " R6"}, "done pulse", done, 1'b0);
        chk({tag, " R7"}, "no stray op", {busy, mem_we, mem_re}, 3'b000);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        sp_model = INIT_SP;
        repeat (3) @(negedge clk);
        chk("R10", "reset sp", sp_out, INIT_SP);
        chk("R10", "reset busy/done", {busy, done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "sp after release", sp_out, INIT_SP);
        // free-slot discipline
        run_op(1, 0, 0, 16'h005A);
        run_op(1, 1, 0, 16'h1234, " R8");
        run_op(1, 0, 0, 16'h0066, " R8");
        run_op(0, 0, 0, 16'h0000, " R8");
        run_op(0, 1, 0, 16'h0000, " R7 poke", 0, 1);
        run_op(0, 0, 0, 16'h0000);
        // occupied-slot discipline
        run_op(1, 1, 1, 16'hBEEF);
        run_op(1, 1, 1, 16'hCAFE, " R8");
        run_op(1, 0, 1, 16'h3399, " R9 both", 1, 0);
        run_op(0, 0, 1, 16'h0000);
        run_op(0, 1, 1, 16'h0000, " R8", 0, 1);
        run_op(0, 1, 1, 16'h0000);
        run_op(0, 0, 1, 16'h0000);
        // back-to-back with mode switch
        run_op(1, 1, 0, 16'hA55A, " R2");
        run_op(0, 1, 1, 16'h0000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule